// File: doc/BRIEF.md
# Adaptive Flowlet Path Selector

This block spreads packets over a set of equal-cost egress paths. Each packet is sorted into a flow. The flow is named by a flow identifier, which is folded into an index for a small flow table. For each slot, the table keeps a valid flag, the timestamp of the slot's most recent packet, a flowlet counter and the path currently in use. A free-running cycle counter provides the timestamps.

A packet that arrives after a long enough silence on its flow opens a new flowlet. Only then may the flow move to another path. Every other packet follows the path stored for its flow, so packets inside a burst never take different routes.

The idle time that counts as "long enough" depends on congestion. While the egress queue is lightly loaded, a long threshold keeps flows on their paths. Once the queue fills past half of its capacity, a short threshold lets flows rebalance quickly. The long threshold returns only after the queue has drained below a quarter of its capacity.

Top module: `flowlet_path_sel`

## Requirements
- R1: After reset, `path_valid` is low, every table slot is invalid, and the threshold mode is relaxed.
- R2: A packet whose gap to the previous packet in its slot is less than or equal to the active threshold gets the stored path of that slot, unchanged.
- R3: A packet whose gap is strictly greater than the active threshold opens a flowlet. The slot counter increments (modulo 2^TABLE_BITS), and the new path is (slot_index XOR new_counter) mod NUM_PATHS.
- R4: The mode becomes aggressive (threshold GAP_AGGR) at a clock edge where 2*q_depth > buf_cap.
- R5: Aggressive mode returns to relaxed (threshold GAP_RELAX) only at an edge where 4*q_depth < buf_cap. Between those two levels the mode holds.
- R6: `path_idx` is always below NUM_PATHS when `path_valid` is high.
- R7: `path_valid` is high exactly one cycle after `pkt_valid` was high, and `path_idx` belongs to that packet.
- R8: A packet that hits an invalid slot opens a flowlet. The slot counter is set to 0, the path is slot_index mod NUM_PATHS, and the slot becomes valid.
- R9: A mode change decided at an edge applies only to packets presented after that edge. A packet presented together with the crossing depth still uses the old threshold.
- R10: The gap is (now - stored) modulo 2^TS_W, where time counts clock cycles, so the gap stays correct when the timestamp counter wraps.
- R11: The slot index is the XOR of all TABLE_BITS-wide slices of `flow_id`, starting at bit 0 and padding the top slice with zeros. Flows that share an index share one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | A packet is presented this cycle |
| flow_id | input | FLOW_W | Flow identifier of the packet |
| q_depth | input | DEPTH_W | Current egress queue occupancy |
| buf_cap | input | DEPTH_W | Egress buffer capacity |
| path_valid | output | 1 | `path_idx` carries a decision |
| path_idx | output | $clog2(NUM_PATHS) | Chosen egress path |

## Verification
The assertions take several things for granted:
- GAP_AGGR is at least one cycle, so a back-to-back packet on the same flow never crosses a flowlet boundary.
- The inputs carry defined values from the release of the internal reset onward.
- `buf_cap` is stable enough that the hysteresis band has a meaning.

The stimulus holds `buf_cap` fixed and moves `q_depth` only between clear levels inside, above and below the band. It also places gaps exactly on, just under and just over each threshold, and it runs long idle stretches so that the timestamp counter wraps.

// File: rtl/flowlet_pkg.sv
package flowlet_pkg;
  typedef enum logic {
    MODE_RELAXED    = 1'b0,
    MODE_AGGRESSIVE = 1'b1
  } gap_mode_e;
endpackage

// File: rtl/fl_rst_sync.sv
module fl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/fl_ts_counter.sv
module fl_ts_counter #(
  parameter int TS_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);
  logic [TS_W-1:0] ts_d;

  always_comb ts_d = ts + TS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts_d;
  end
endmodule

// File: rtl/fl_mode_ctrl.sv
module fl_mode_ctrl
  import flowlet_pkg::*;
#(
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] q_depth,
  input  logic [DEPTH_W-1:0] buf_cap,
  output gap_mode_e          mode
);
  localparam int EXT_W = DEPTH_W + 2;

  logic [EXT_W-1:0] depth_x2, depth_x4, cap_ext;
  logic             above_half, below_quarter;
  gap_mode_e        mode_d;

  always_comb begin
    depth_x2      = {1'b0, q_depth, 1'b0};
    depth_x4      = {q_depth, 2'b00};
    cap_ext       = {2'b00, buf_cap};
    above_half    = depth_x2 > cap_ext;
    below_quarter = depth_x4 < cap_ext;
    mode_d        = mode;
    if (mode == MODE_RELAXED && above_half)
      mode_d = MODE_AGGRESSIVE;
    else if (mode == MODE_AGGRESSIVE && below_quarter)
      mode_d = MODE_RELAXED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_RELAXED;
    else        mode <= mode_d;
  end
endmodule

// File: rtl/fl_flow_table.sv
module fl_flow_table #(
  parameter int TABLE_BITS = 4,
  parameter int TS_W       = 20,
  parameter int PATH_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TABLE_BITS-1:0] rd_idx,
  output logic                  rd_valid,
  output logic [TS_W-1:0]       rd_ts,
  output logic [TABLE_BITS-1:0] rd_cnt,
  output logic [PATH_W-1:0]     rd_path,
  input  logic                  wr_en,
  input  logic [TABLE_BITS-1:0] wr_idx,
  input  logic [TS_W-1:0]       wr_ts,
  input  logic [TABLE_BITS-1:0] wr_cnt,
  input  logic [PATH_W-1:0]     wr_path
);
  localparam int ENTRIES = 1 << TABLE_BITS;

  logic                  slot_vld  [ENTRIES];
  logic [TS_W-1:0]       slot_ts   [ENTRIES];
  logic [TABLE_BITS-1:0] slot_cnt  [ENTRIES];
  logic [PATH_W-1:0]     slot_path [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic slot_we;
    always_comb slot_we = wr_en && (wr_idx == TABLE_BITS'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[e]  <= 1'b0;
        slot_ts[e]   <= '0;
        slot_cnt[e]  <= '0;
        slot_path[e] <= '0;
      end else if (slot_we) begin
        slot_vld[e]  <= 1'b1;
        slot_ts[e]   <= wr_ts;
        slot_cnt[e]  <= wr_cnt;
        slot_path[e] <= wr_path;
      end
    end
  end

  always_comb begin
    rd_valid = slot_vld[rd_idx];
    rd_ts    = slot_ts[rd_idx];
    rd_cnt   = slot_cnt[rd_idx];
    rd_path  = slot_path[rd_idx];
  end
endmodule

// File: rtl/flowlet_path_sel.sv
module flowlet_path_sel
  import flowlet_pkg::*;
#(
  parameter int NUM_PATHS  = 4,
  parameter int TABLE_BITS = 4,
  parameter int FLOW_W     = 16,
  parameter int TS_W       = 20,
  parameter int DEPTH_W    = 16,
  parameter int GAP_RELAX  = 10000,
  parameter int GAP_AGGR   = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pkt_valid,
  input  logic [FLOW_W-1:0]            flow_id,
  input  logic [DEPTH_W-1:0]           q_depth,
  input  logic [DEPTH_W-1:0]           buf_cap,
  output logic                         path_valid,
  output logic [$clog2(NUM_PATHS)-1:0] path_idx
);
  localparam int PATH_W   = $clog2(NUM_PATHS);
  localparam int N_SLICES = (FLOW_W + TABLE_BITS - 1) / TABLE_BITS;
  localparam int PAD_W    = N_SLICES * TABLE_BITS;
  localparam logic [TS_W-1:0] THR_RELAX = TS_W'(GAP_RELAX);
  localparam logic [TS_W-1:0] THR_AGGR  = TS_W'(GAP_AGGR);

  logic                  rst_sync_n;
  logic [TS_W-1:0]       ts_now;
  gap_mode_e             mode;
  logic                  mode_aggr;
  logic [TABLE_BITS-1:0] slot_idx;
  logic                  rd_valid;
  logic [TS_W-1:0]       rd_ts;
  logic [TABLE_BITS-1:0] rd_cnt;
  logic [PATH_W-1:0]     rd_path;
  logic [TS_W-1:0]       gap, thr;
  logic                  boundary;
  logic [TABLE_BITS-1:0] cnt_new;
  logic [PATH_W-1:0]     path_new;
  logic [31:0]           mix;
  logic                  path_valid_d;
  logic [PATH_W-1:0]     path_idx_d;

  fl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  fl_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_sync_n), .ts(ts_now)
  );

  fl_mode_ctrl #(.DEPTH_W(DEPTH_W)) u_mode (
    .clk(clk), .rst_n(rst_sync_n), .q_depth(q_depth), .buf_cap(buf_cap),
    .mode(mode)
  );

  always_comb mode_aggr = (mode == MODE_AGGRESSIVE);

  // fold flow identifier into a table index
  always_comb begin
    logic [PAD_W-1:0] padded;
    padded   = PAD_W'(flow_id);
    slot_idx = '0;
    for (int s = 0; s < N_SLICES; s++)
      slot_idx = slot_idx ^ padded[s*TABLE_BITS +: TABLE_BITS];
  end

  fl_flow_table #(.TABLE_BITS(TABLE_BITS), .TS_W(TS_W), .PATH_W(PATH_W)) u_tbl (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_idx(slot_idx), .rd_valid(rd_valid), .rd_ts(rd_ts),
    .rd_cnt(rd_cnt), .rd_path(rd_path),
    .wr_en(pkt_valid), .wr_idx(slot_idx), .wr_ts(ts_now),
    .wr_cnt(cnt_new), .wr_path(path_new)
  );

  // flowlet decision
  always_comb begin
    gap      = ts_now - rd_ts;
    thr      = mode_aggr ? THR_AGGR : THR_RELAX;
    boundary = !rd_valid || (gap > thr);
    if (!rd_valid)     cnt_new = '0;
    else if (boundary) cnt_new = rd_cnt + TABLE_BITS'(1);
    else               cnt_new = rd_cnt;
    mix = 32'(slot_idx ^ cnt_new) % 32'(NUM_PATHS);
    path_new = boundary ? mix[PATH_W-1:0] : rd_path;
    path_valid_d = pkt_valid;
    path_idx_d   = pkt_valid ? path_new : path_idx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      path_valid <= 1'b0;
      path_idx   <= '0;
    end else begin
      path_valid <= path_valid_d;
      path_idx   <= path_idx_d;
    end
  end
endmodule

// File: rtl/fl_path_sel_chk.sv
module fl_path_sel_chk #(
  parameter int NUM_PATHS = 4,
  parameter int FLOW_W    = 16,
  parameter int DEPTH_W   = 16
) (
  input logic                         clk,
  input logic                         rst_sync_n,
  input logic                         pkt_valid,
  input logic [FLOW_W-1:0]            flow_id,
  input logic [DEPTH_W-1:0]           q_depth,
  input logic [DEPTH_W-1:0]           buf_cap,
  input logic                         path_valid,
  input logic [$clog2(NUM_PATHS)-1:0] path_idx,
  input logic                         mode_aggr
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pkt_valid |=> path_valid);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pkt_valid |=> !path_valid);

  assert_path_range_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    path_valid |-> (32'(path_idx) < 32'(NUM_PATHS)));

  assert_enter_aggr_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mode_aggr) |-> $past({1'b0, q_depth, 1'b0} > {2'b00, buf_cap}));

  assert_leave_aggr_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(mode_aggr) |-> $past({q_depth, 2'b00} < {2'b00, buf_cap}));

  assert_hold_in_flowlet_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pkt_valid && $past(pkt_valid) && flow_id == $past(flow_id))
      |=> (path_idx == $past(path_idx)));
endmodule

bind flowlet_path_sel fl_path_sel_chk #(
  .NUM_PATHS(NUM_PATHS), .FLOW_W(FLOW_W), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .pkt_valid(pkt_valid),
  .flow_id(flow_id), .q_depth(q_depth), .buf_cap(buf_cap),
  .path_valid(path_valid), .path_idx(path_idx), .mode_aggr(mode_aggr)
);

// File: tb/tb_flowlet_path_sel.sv
module tb_flowlet_path_sel;
  localparam int NP = 4, TB = 3, FW = 12, TSW = 8, DW = 8;
  localparam int RELAX = 40, AGGR = 6;
  localparam int ENT = 1 << TB;

  logic clk, rst_n, pkt_valid;
  logic [FW-1:0] flow_id;
  logic [DW-1:0] q_depth, buf_cap;
  logic path_valid;
  logic [1:0] path_idx;

  flowlet_path_sel #(.NUM_PATHS(NP), .TABLE_BITS(TB), .FLOW_W(FW), .TS_W(TSW),
    .DEPTH_W(DW), .GAP_RELAX(RELAX), .GAP_AGGR(AGGR)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .flow_id(flow_id),
    .q_depth(q_depth), .buf_cap(buf_cap), .path_valid(path_valid),
    .path_idx(path_idx));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference state
  int now = 0;
  bit aggr = 0;
  bit m_vld[ENT];
  int m_ts[ENT], m_cnt[ENT], m_path[ENT];

  function automatic int slot_of(int fid);
    int r = 0;
    for (int k = 0; k < FW; k += TB) r ^= (fid >> k) & (ENT - 1);
    return r;
  endfunction

  task automatic check(string tag, bit ev, int ep);
    total++;
    if (path_valid !== ev || (ev && path_idx !== ep[1:0])) begin
      bad++;
      $display("FAIL %s: valid=%0b path=%0d expected valid=%0b path=%0d",
               tag, path_valid, path_idx, ev, ep);
    end
  endtask

  task automatic step(bit v, int fid, string tag);
    bit ev;
    int ep = 0;
    @(negedge clk);
    pkt_valid = v;
    flow_id   = fid[FW-1:0];
    ev = v;
    if (v) begin
      int s = slot_of(fid);
      int gap = (now - m_ts[s]) & ((1 << TSW) - 1);
      int thr = aggr ? AGGR : RELAX;
      if (!m_vld[s]) begin
        m_cnt[s] = 0; m_path[s] = s % NP;
      end else if (gap > thr) begin
        m_cnt[s] = (m_cnt[s] + 1) % ENT; m_path[s] = (s ^ m_cnt[s]) % NP;
      end
      m_vld[s] = 1; m_ts[s] = now;
      ep = m_path[s];
    end
    if (!aggr && 2 * int'(q_depth) > int'(buf_cap)) aggr = 1;
    else if (aggr && 4 * int'(q_depth) < int'(buf_cap)) aggr = 0;
    now++;
    @(posedge clk);
    #1;
    check(tag, ev, ep);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_vld[i] = 0; m_ts[i] = 0; m_cnt[i] = 0; m_path[i] = 0; end
    rst_n = 0; pkt_valid = 0; flow_id = '0; q_depth = 8'd10; buf_cap = 8'd100;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (path_valid !== 1'b0) begin bad++; $display("FAIL R1: valid=%0b expected 0", path_valid); end
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk);
    // internal reset now released; model time starts at zero
    idle(3, "R1 idle after reset");
    // R8/R11: first packets hit invalid slots
    step(1, 12'h005, "R8 first packet slot 5");
    step(1, 12'h005, "R2 back-to-back same flow");
    step(1, 12'h00A, "R11 slot 1^2=3");
    step(1, 12'h001, "R8 slot 1");
    step(1, 12'h008, "R11 shares slot 1");
    // R2/R3 relaxed threshold
    idle(20, "R2 idle");
    step(1, 12'h005, "R2 gap under relaxed");
    idle(39, "R2 idle");
    step(1, 12'h005, "R2 gap equal relaxed");
    idle(40, "R3 idle");
    step(1, 12'h005, "R3 gap over relaxed");
    idle(44, "R3 idle");
    step(1, 12'h005, "R3 second boundary");
    // R4/R9: raise depth together with a packet
    idle(9, "R9 idle");
    q_depth = 8'd80;
    step(1, 12'h005, "R9 packet with crossing depth uses relaxed");
    idle(9, "R4 idle");
    step(1, 12'h005, "R4 aggressive gap over");
    idle(5, "R4 idle");
    step(1, 12'h005, "R4 gap equal aggressive");
    // R5: middle band holds aggressive
    q_depth = 8'd40;
    idle(9, "R5 idle");
    step(1, 12'h005, "R5 band keeps aggressive");
    step(1, 12'h00A, "R5 other flow");
    // R5: drain below quarter
    q_depth = 8'd20;
    idle(9, "R5 idle");
    step(1, 12'h005, "R5 relaxed again");
    idle(9, "R5 idle");
    step(1, 12'h005, "R5 relaxed gap under");
    // R10: long idle crosses timestamp wrap
    idle(230, "R10 idle");
    step(1, 12'h00A, "R10 wrapped gap");
    idle(15, "R10 idle");
    step(1, 12'h00A, "R10 gap under after wrap");
    // R3: counter wrap over many boundaries
    for (int i = 0; i < 10; i++) begin
      idle(41, "R3 idle");
      step(1, 12'h001, "R3 repeated boundary");
    end
    // R7/R6 mixed burst
    for (int i = 0; i < 24; i++) step(i % 3 != 0, i * 37, "R7 mixed burst");
    idle(2, "R7 tail");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule